// File: doc/BRIEF.md
# Input Pin Debounce Filter

This block cleans up one asynchronous input pin before it reaches the interrupt and status logic. The raw pin first passes through a two-stage synchronizer into the system clock domain. A filter stage then decides when the filtered level may follow the synchronized level. It measures how long the input has stayed stable by counting pulses of a slow real-time tick, nominally 32.768 kHz. Each pulse arrives as a one-cycle enable in the system clock domain.

The stable time comes from three things: a tick unit chosen by two select bits, a 4-bit count of those units, and a 2-bit filter type. The filter can be bypassed. It can reject short pulses in both directions. It can also let pulses of one polarity through at once while filtering changes of the other polarity. Writing a new configuration restarts the measurement and loads the current synchronized level onto the output.

Top module: `pin_debounce_filter`

## Requirements
- R1: `pin_sync` equals the level `pin_raw` had two system clock edges earlier, through two flops cleared by reset.
- R2: The tick unit is selected by {`cfg_large`,`cfg_unit`}: 00 gives 2 ticks, 01 gives 8 ticks, 10 gives 512 ticks, and 11 gives 2048 ticks.
- R3: The stable window is `cfg_count` times the selected unit, in ticks. A count of 0 behaves as a count of 1. The internal tick counter always stays below the window.
- R4: `cfg_mode` = 0 is bypass. In bypass, `pin_filt` equals `pin_sync` in the same cycle.
- R5: `cfg_mode` = 3 rejects glitches in both directions. `pin_filt` takes a new level only after `pin_sync` has held that level, different from `pin_filt`, across a full window of ticks. If `pin_sync` returns to the level of `pin_filt` before the window ends, the count starts again from zero.
- R6: `cfg_mode` = 1 passes low pulses. A falling `pin_sync` reaches `pin_filt` on the next edge. A rising change must last the full window.
- R7: `cfg_mode` = 2 passes high pulses. A rising `pin_sync` reaches `pin_filt` on the next edge. A falling change must last the full window.
- R8: The count advances only on cycles where `tick` is high. With `tick` held low, a filtered change never completes.
- R9: A one-cycle `cfg_wr` pulse restarts the count. On the next edge it also loads `pin_filt` with `pin_sync`.
- R10: During and after reset, `pin_filt` and `pin_sync` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous raw pin level |
| tick | input | 1 | One-cycle pulse per real-time tick |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Filter type: 0 bypass, 1 pass low pulses, 2 pass high pulses, 3 reject both |
| cfg_unit | input | 1 | Unit select, low bit |
| cfg_large | input | 1 | Unit select, high bit |
| cfg_count | input | 4 | Number of units in the stable window |
| pin_filt | output | 1 | Debounced level |
| pin_sync | output | 1 | Synchronized raw level |

## Verification
The hardest situation to reach is a partial count that is thrown away. The input has to stay changed for several ticks and then return before the window ends. If the counter were not cleared, a second change would complete early. The stimulus holds tick high on every cycle and keeps the pin high for exactly three ticks against a four-tick window. It then raises the pin again and checks that the output still waits for the whole window. The largest windows stay reachable because the tick is held high continuously, so a 2048-tick unit costs only that many clock cycles.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    DBF_BYPASS      = 2'd0,
    DBF_KEEP_LOW    = 2'd1,
    DBF_KEEP_HIGH   = 2'd2,
    DBF_REJECT_BOTH = 2'd3
  } dbf_mode_e;

  // log2 of the largest unit, used to size the window counter
  localparam int UNIT_LOG_MAX = 11;

  // real-time ticks per unit for a select pair
  function automatic int unit_ticks(input logic large_bit, input logic unit_bit);
    case ({large_bit, unit_bit})
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  // total ticks in the stable window; a zero count acts as one unit
  function automatic int window_ticks(input int count, input logic large_bit,
                                      input logic unit_bit);
    int n;
    n = (count == 0) ? 1 : count;
    return n * unit_ticks(large_bit, unit_bit);
  endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic din;
    if (i == 0) begin : g_first
      assign din = d;
    end else begin : g_next
      assign din = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= din;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbf_window_timer.sv
module dbf_window_timer #(
  parameter int TMR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [TMR_W-1:0] target,
  output logic             expire,
  output logic [TMR_W-1:0] cnt
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  assign expire = advance && !clear && (cnt == target - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear || expire)  cnt <= '0;
    else if (advance)          cnt <= cnt + ONE;
  end
endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_unit,
  input  logic             cfg_large,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             pin_filt,
  output logic             pin_sync
);
  import dbf_pkg::*;

  localparam int TMR_W = CNT_W + UNIT_LOG_MAX;

  dbf_mode_e        mode;
  logic             out_q;
  logic             mismatch;
  logic             pass_now;
  logic             tmr_clear;
  logic             tmr_adv;
  logic             expire;
  logic [TMR_W-1:0] target;
  logic [TMR_W-1:0] tmr_cnt;

  assign mode = dbf_mode_e'(cfg_mode);

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw),
    .q     (pin_sync)
  );

  assign target = TMR_W'(window_ticks(int'(cfg_count), cfg_large, cfg_unit));

  // events named for the checker
  assign mismatch = (pin_sync != out_q);
  assign pass_now = mismatch &&
                    (((mode == DBF_KEEP_LOW)  && !pin_sync) ||
                     ((mode == DBF_KEEP_HIGH) &&  pin_sync));
  assign tmr_clear = cfg_wr || !mismatch || (mode == DBF_BYPASS) || pass_now;
  assign tmr_adv   = tick && !tmr_clear;

  dbf_window_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .advance (tmr_adv),
    .target  (target),
    .expire  (expire),
    .cnt     (tmr_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= 1'b0;
    else if (cfg_wr || (mode == DBF_BYPASS) || pass_now || expire)
      out_q <= pin_sync;
  end

  assign pin_filt = (mode == DBF_BYPASS) ? pin_sync : out_q;

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int TMR_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cfg_wr,
  input logic [1:0]       cfg_mode,
  input logic             pin_sync,
  input logic             pin_filt,
  input logic             expire,
  input logic [TMR_W-1:0] tmr_cnt,
  input logic [TMR_W-1:0] target
);
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cnt < target); // R3

  AST_REJECT_WAITS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3 && $past(cfg_mode) == 2'd3 && !$past(cfg_wr) &&
     pin_filt != $past(pin_filt)) |-> $past(expire)); // R5

  AST_LOW_PASSES_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && !cfg_wr && !pin_sync && pin_filt)
      |=> (cfg_mode == 2'd0) || !pin_filt); // R6

  AST_HIGH_PASSES_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && !cfg_wr && pin_sync && !pin_filt)
      |=> (cfg_mode == 2'd0) || pin_filt); // R7

  AST_NO_COUNT_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(tmr_cnt) || tmr_cnt == '0)); // R8

  AST_WRITE_LOADS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_mode == 2'd0) || (pin_filt == $past(pin_sync))); // R9
endmodule

bind pin_debounce_filter dbf_checker #(.TMR_W(TMR_W)) u_dbf_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cfg_wr   (cfg_wr),
  .cfg_mode (cfg_mode),
  .pin_sync (pin_sync),
  .pin_filt (pin_filt),
  .expire   (expire),
  .tmr_cnt  (tmr_cnt),
  .target   (target)
);

// File: tb/tb_pin_debounce_filter.sv
`timescale 1ns/1ps
module tb_pin_debounce_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'd3;
  logic       cfg_unit = 1'b0;
  logic       cfg_large = 1'b0;
  logic [3:0] cfg_count = 4'd1;
  logic       pin_filt;
  logic       pin_sync;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pin_debounce_filter dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .cfg_unit(cfg_unit), .cfg_large(cfg_large),
    .cfg_count(cfg_count), .pin_filt(pin_filt), .pin_sync(pin_sync)
  );

  // stimulus table: {mode[1:0], large, unit, count[3:0]}
  localparam logic [7:0] VEC [0:8] = '{
    {2'd3, 1'b0, 1'b0, 4'd1},
    {2'd3, 1'b0, 1'b0, 4'd0},
    {2'd3, 1'b0, 1'b1, 4'd3},
    {2'd3, 1'b1, 1'b0, 4'd2},
    {2'd3, 1'b1, 1'b1, 4'd1},
    {2'd3, 1'b0, 1'b1, 4'd15},
    {2'd1, 1'b0, 1'b1, 4'd2},
    {2'd2, 1'b0, 1'b0, 4'd5},
    {2'd0, 1'b1, 1'b1, 4'd7}
  };

  // ticks per unit: 2 shifted by 2 per unit bit and 8 per large bit
  function automatic int exp_window(input logic l, input logic u, input logic [3:0] c);
    int units;
    units = (c == 4'd0) ? 1 : int'(c);
    return units * (2 << (int'(u) * 2 + int'(l) * 8));
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic apply_cfg(input logic [1:0] m, input logic l, input logic u,
                           input logic [3:0] c);
    @(negedge clk);
    cfg_mode = m; cfg_large = l; cfg_unit = u; cfg_count = c; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // drive a new level, expect pin_filt to change after exactly lat edges
  task automatic edge_run(input logic val, input int lat, input string req);
    pin_raw = val;
    repeat (lat - 1) @(negedge clk);
    check(pin_filt, !val, req);
    @(negedge clk);
    check(pin_filt, val, req);
    repeat (3) @(negedge clk);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(pin_filt, 1'b0, "R10 filt in reset");
    check(pin_sync, 1'b0, "R10 sync in reset");
    rst_n = 1'b1;
    tick  = 1'b1;
    repeat (2) @(negedge clk);
    check(pin_filt, 1'b0, "R10 filt after reset");

    // table walk: R2 R3 R4 R5 R6 R7
    foreach (VEC[i]) begin
      logic [1:0] m;
      logic l, u;
      logic [3:0] c;
      int w, lr, lf;
      {m, l, u, c} = VEC[i];
      w = exp_window(l, u, c);
      apply_cfg(m, l, u, c);
      case (m)
        2'd0:    begin lr = 2;     lf = 2;     end
        2'd1:    begin lr = 2 + w; lf = 3;     end
        2'd2:    begin lr = 3;     lf = 2 + w; end
        default: begin lr = 2 + w; lf = 2 + w; end
      endcase
      if (m == 2'd0) begin
        pin_raw = 1'b1;
        @(negedge clk);
        check(pin_sync, 1'b0, "R1 sync one edge");
        check(pin_filt, 1'b0, "R4 bypass one edge");
        @(negedge clk);
        check(pin_sync, 1'b1, "R1 sync two edges");
        check(pin_filt, 1'b1, "R4 bypass follows sync");
        repeat (3) @(negedge clk);
        edge_run(1'b0, lf, "R4 bypass fall");
      end else begin
        edge_run(1'b1, lr, "R2 R3 R5 R6 R7 rise");
        edge_run(1'b0, lf, "R2 R3 R5 R6 R7 fall");
      end
    end

    // R5 restart: window 4 ticks, pin high for only 3 ticks
    apply_cfg(2'd3, 1'b0, 1'b0, 4'd2);
    pin_raw = 1'b1;
    repeat (3) @(negedge clk);
    pin_raw = 1'b0;
    repeat (10) @(negedge clk);
    check(pin_filt, 1'b0, "R5 short pulse rejected");
    edge_run(1'b1, 2 + 4, "R5 count restarted");
    edge_run(1'b0, 2 + 4, "R5 return low");

    // R8 no tick, no progress
    apply_cfg(2'd3, 1'b0, 1'b0, 4'd1);
    tick = 1'b0;
    pin_raw = 1'b1;
    repeat (40) @(negedge clk);
    check(pin_filt, 1'b0, "R8 held without tick");
    tick = 1'b1;
    @(negedge clk);
    check(pin_filt, 1'b0, "R8 first tick");
    @(negedge clk);
    check(pin_filt, 1'b1, "R8 second tick completes");
    pin_raw = 1'b0;
    repeat (10) @(negedge clk);

    // R9 config write loads the synchronized level at once
    apply_cfg(2'd3, 1'b1, 1'b1, 4'd15);
    pin_raw = 1'b1;
    repeat (10) @(negedge clk);
    check(pin_filt, 1'b0, "R9 before write");
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(pin_filt, 1'b1, "R9 write loads sync");

    done = 1'b1;
    report();
    $finish;
  end
endmodule